// File: doc/BRIEF.md
# Cascade Partial-Sum Alignment Stage

This stage sits at the end of one convolution device in an array of such devices. Each device in the array computes the result for one tile of a larger window. The stage receives two sums. The first is the device's own local partial sum. The second is a cascade sum, which comes from the neighbouring device earlier in the row or from the device row above. The stage delays each sum by its own programmable amount so that both refer to the same output pixel. It adds them and passes the total to the next device through a fixed four-register output pipeline.

The local sum can be delayed by 0, 4, 8 or 12 pixel clocks, with an optional further 16 clocks on top. Together these cover row-to-row offsets of up to 28 clocks. The cascade sum can be delayed by 4 extra clocks when the upstream tile is eight pixels wide. That delay, plus the 4-clock output latency of the upstream device, produces the 8-pixel horizontal offset. For pixels split across two devices, the device that holds the upper byte shifts its local sum left by eight places before the add. The device at the head of a chain ignores its cascade input.

Top module: `cascade_sum_align`

## Requirements
- R1: A synchronous reset clears every pipeline stage, so `exp_out` is zero during reset. It stays zero until data presented after reset has had time to reach the output.
- R2: `cfg_loc_dly` sets the local-sum delay in steps of 4 clocks: 00 gives 0, 01 gives 4, 10 gives 8 and 11 gives 12 clocks.
- R3: When `cfg_loc_long` is 1, it adds 16 clocks to the R2 delay. The local delay therefore reaches a maximum of 28 clocks.
- R4: When `cfg_exp_dly` is 1, the cascade input is delayed by 4 clocks before the add. When it is 0, the cascade input has no added delay.
- R5: When `cfg_first` is 1, the cascade input has no effect on `exp_out`. The output then carries the local contribution alone.
- R6: When `cfg_shift8` is 1, the sign-extended local sum is multiplied by 256 (shifted 8 places toward the MSB) before the add.
- R7: The stage forms the 32-bit sum of the two aligned operands, modulo 2^32. That sum appears on `exp_out` exactly 4 clocks later. For a local sample presented at clock n, the total latency is 4 + the local delay.
- R8: `local_sum` is a signed two's-complement value. The stage sign-extends it to 32 bits before the shift and the add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_loc_dly | input | 2 | Coarse local-sum delay code (R2) |
| cfg_loc_long | input | 1 | Adds 16 clocks to the local delay |
| cfg_exp_dly | input | 1 | Adds 4 clocks to the cascade input delay |
| cfg_shift8 | input | 1 | Shift the local sum left by 8 places |
| cfg_first | input | 1 | Head of chain: cascade input ignored |
| local_sum | input | 22 | Signed local convolver partial sum |
| exp_in | input | 32 | Cascade sum from the upstream device |
| exp_out | output | 32 | Aligned total toward the downstream device |

## Verification
The bench sends single impulses into each path under all eight local delay settings and both cascade delay settings. A design that decodes a code wrongly, or misses one register, would show the impulse one or more clocks away from the expected cycle. It would also show spurious values where zero is expected.

Random streams run with a nonzero cascade input while the head-of-chain setting is on. A design that leaked the cascade input would corrupt the total. Negative local values are mixed with the 8-place shift. A design that zero-extended, or that shifted only the low bits, would give wrong upper bits.

A reset in the middle of a data stream must leave the output at zero. Stale pipeline contents would show up there.

// File: rtl/csa_pkg.sv
package csa_pkg;
   // Step size of the coarse local delay code
   localparam int unsigned COARSE_STEP = 4;
   // Additional delay selected by the long-delay bit
   localparam int unsigned LONG_ADD    = 16;
   // Extra cascade input delay
   localparam int unsigned EXP_ADD     = 4;
   // Register stages on the output path
   localparam int unsigned OUT_LAT     = 4;
   // Place shift for split-precision pixels
   localparam int unsigned HI_SHIFT    = 8;

   typedef struct packed {
      logic [1:0] loc_code;
      logic       loc_long;
      logic       exp_dly;
      logic       shift8;
      logic       first;
   } csa_cfg_t;
endpackage

// File: rtl/csa_tap_delay.sv
module csa_tap_delay #(
   parameter int unsigned W       = 22,
   parameter int unsigned MAX_DLY = 28,
   parameter int unsigned SEL_W   = (MAX_DLY > 0) ? $clog2(MAX_DLY + 1) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] sel,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     dout
);
   generate
      if (W == 0) begin : g_bad_width
         $error("csa_tap_delay: W must be nonzero");
      end

      if (MAX_DLY == 0) begin : g_wire
         assign dout = din;
      end else begin : g_chain
         logic [W-1:0] stage [1:MAX_DLY];

         for (genvar i = 1; i <= MAX_DLY; i++) begin : g_stage
            if (i == 1) begin : g_head
               always_ff @(posedge clk) begin
                  if (rst) stage[i] <= '0;
                  else     stage[i] <= din;
               end
            end else begin : g_body
               always_ff @(posedge clk) begin
                  if (rst) stage[i] <= '0;
                  else     stage[i] <= stage[i-1];
               end
            end
         end

         always_comb begin
            dout = din;
            for (int k = 1; k <= MAX_DLY; k++) begin
               if (int'(sel) == k) dout = stage[k];
            end
            if (int'(sel) > MAX_DLY) dout = stage[MAX_DLY];
         end
      end
   endgenerate
endmodule

// File: rtl/csa_combine.sv
module csa_combine #(
   parameter int unsigned LOC_W = 22,
   parameter int unsigned ACC_W = 32,
   parameter int unsigned SHIFT = 8
) (
   input  logic [LOC_W-1:0] loc_tap,
   input  logic [ACC_W-1:0] exp_tap,
   input  logic             shift_en,
   input  logic             first,
   output logic [ACC_W-1:0] sum
);
   localparam int unsigned EXT_W = ACC_W - LOC_W;

   logic [ACC_W-1:0] loc_ext;
   logic [ACC_W-1:0] loc_op;
   logic [ACC_W-1:0] exp_op;

   generate
      if (LOC_W + SHIFT > ACC_W) begin : g_bad_acc
         $error("csa_combine: ACC_W too narrow for shifted local sum");
      end
      if (EXT_W == 0) begin : g_no_ext
         assign loc_ext = loc_tap;
      end else begin : g_ext
         assign loc_ext = {{EXT_W{loc_tap[LOC_W-1]}}, loc_tap};
      end
   endgenerate

   always_comb begin
      loc_op = shift_en ? (loc_ext << SHIFT) : loc_ext;
      exp_op = first ? '0 : exp_tap;
      sum    = loc_op + exp_op;
   end
endmodule

// File: rtl/csa_out_pipe.sv
module csa_out_pipe #(
   parameter int unsigned W   = 32,
   parameter int unsigned LAT = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (LAT == 0) begin : g_wire
         assign dout = din;
      end else begin : g_regs
         logic [W-1:0] pipe [0:LAT-1];
         for (genvar i = 0; i < LAT; i++) begin : g_stage
            if (i == 0) begin : g_head
               always_ff @(posedge clk) begin
                  if (rst) pipe[i] <= '0;
                  else     pipe[i] <= din;
               end
            end else begin : g_body
               always_ff @(posedge clk) begin
                  if (rst) pipe[i] <= '0;
                  else     pipe[i] <= pipe[i-1];
               end
            end
         end
         assign dout = pipe[LAT-1];
      end
   endgenerate
endmodule

// File: rtl/cascade_sum_align.sv
module cascade_sum_align
   import csa_pkg::*;
#(
   parameter int unsigned LOC_W  = 22,
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned STEP   = COARSE_STEP,
   parameter int unsigned LONG   = LONG_ADD,
   parameter int unsigned EXTRA  = EXP_ADD,
   parameter int unsigned LAT    = OUT_LAT,
   parameter int unsigned SHIFT  = HI_SHIFT
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       cfg_loc_dly,
   input  logic             cfg_loc_long,
   input  logic             cfg_exp_dly,
   input  logic             cfg_shift8,
   input  logic             cfg_first,
   input  logic [LOC_W-1:0] local_sum,
   input  logic [ACC_W-1:0] exp_in,
   output logic [ACC_W-1:0] exp_out
);
   localparam int unsigned LOC_MAX = 3 * STEP + LONG;
   localparam int unsigned LSEL_W  = (LOC_MAX > 0) ? $clog2(LOC_MAX + 1) : 1;
   localparam int unsigned ESEL_W  = (EXTRA > 0) ? $clog2(EXTRA + 1) : 1;

   generate
      if (LOC_W < 2 || LOC_W > ACC_W) begin : g_bad_loc
         $error("cascade_sum_align: LOC_W out of range");
      end
   endgenerate

   csa_cfg_t         cfg;
   logic [LSEL_W-1:0] loc_sel;
   logic [ESEL_W-1:0] exp_sel;
   logic [LOC_W-1:0]  loc_tap;
   logic [ACC_W-1:0]  exp_tap;
   logic [ACC_W-1:0]  sum_w;

   always_comb begin
      cfg.loc_code = cfg_loc_dly;
      cfg.loc_long = cfg_loc_long;
      cfg.exp_dly  = cfg_exp_dly;
      cfg.shift8   = cfg_shift8;
      cfg.first    = cfg_first;
      loc_sel = LSEL_W'(int'(cfg.loc_code) * STEP + (cfg.loc_long ? LONG : 0));
      exp_sel = cfg.exp_dly ? ESEL_W'(EXTRA) : '0;
   end

   csa_tap_delay #(.W(LOC_W), .MAX_DLY(LOC_MAX), .SEL_W(LSEL_W)) i_loc_dly (
      .clk (clk), .rst (rst), .sel (loc_sel), .din (local_sum), .dout (loc_tap)
   );

   csa_tap_delay #(.W(ACC_W), .MAX_DLY(EXTRA), .SEL_W(ESEL_W)) i_exp_dly (
      .clk (clk), .rst (rst), .sel (exp_sel), .din (exp_in), .dout (exp_tap)
   );

   csa_combine #(.LOC_W(LOC_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) i_comb (
      .loc_tap (loc_tap), .exp_tap (exp_tap), .shift_en (cfg.shift8),
      .first (cfg.first), .sum (sum_w)
   );

   csa_out_pipe #(.W(ACC_W), .LAT(LAT)) i_out (
      .clk (clk), .rst (rst), .din (sum_w), .dout (exp_out)
   );
endmodule

// File: rtl/csa_checker.sv
module csa_checker #(
   parameter int unsigned LOC_W = 22,
   parameter int unsigned ACC_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       cfg_loc_dly,
   input logic             cfg_loc_long,
   input logic             cfg_exp_dly,
   input logic             cfg_shift8,
   input logic             cfg_first,
   input logic [LOC_W-1:0] local_sum,
   input logic [ACC_W-1:0] exp_in,
   input logic [LOC_W-1:0] loc_tap,
   input logic [ACC_W-1:0] exp_tap,
   input logic [ACC_W-1:0] sum_w,
   input logic [ACC_W-1:0] exp_out
);
   logic [5:0] run_cnt;
   logic [5:0] cfg_age;
   logic [5:0] cfg_prev;
   logic [5:0] cfg_now;

   assign cfg_now = {cfg_loc_dly, cfg_loc_long, cfg_exp_dly, cfg_shift8, cfg_first};

   always_ff @(posedge clk) begin
      if (rst) begin
         run_cnt  <= '0;
         cfg_age  <= '0;
         cfg_prev <= cfg_now;
      end else begin
         if (run_cnt != 6'd63) run_cnt <= run_cnt + 6'd1;
         cfg_prev <= cfg_now;
         if (cfg_now != cfg_prev) cfg_age <= '0;
         else if (cfg_age != 6'd63) cfg_age <= cfg_age + 6'd1;
      end
   end

   assert_flush_zero_R1: assert property (@(posedge clk) disable iff (rst)
      run_cnt < 6'd4 |-> exp_out == '0);

   assert_out_latency_R7: assert property (@(posedge clk) disable iff (rst)
      run_cnt >= 6'd4 |-> exp_out == $past(sum_w, 4));

   assert_loc_nodelay_R2: assert property (@(posedge clk) disable iff (rst)
      (cfg_loc_dly == 2'b00 && !cfg_loc_long) |-> loc_tap == local_sum);

   assert_loc_dly12_R2: assert property (@(posedge clk) disable iff (rst)
      (run_cnt >= 6'd12 && cfg_age >= 6'd12 && cfg_loc_dly == 2'b11 && !cfg_loc_long)
      |-> loc_tap == $past(local_sum, 12));

   assert_loc_dly28_R3: assert property (@(posedge clk) disable iff (rst)
      (run_cnt >= 6'd28 && cfg_age >= 6'd28 && cfg_loc_dly == 2'b11 && cfg_loc_long)
      |-> loc_tap == $past(local_sum, 28));

   assert_exp_dly_R4: assert property (@(posedge clk) disable iff (rst)
      (run_cnt >= 6'd4 && cfg_age >= 6'd4 && cfg_exp_dly)
      |-> exp_tap == $past(exp_in, 4));

   assert_first_ignores_R5: assert property (@(posedge clk) disable iff (rst)
      (cfg_first && loc_tap == '0) |-> sum_w == '0);

   assert_shift_low_R6: assert property (@(posedge clk) disable iff (rst)
      (cfg_shift8 && cfg_first) |-> sum_w[7:0] == 8'd0);
endmodule

bind cascade_sum_align csa_checker #(.LOC_W(LOC_W), .ACC_W(ACC_W)) i_csa_checker (
   .clk (clk), .rst (rst), .cfg_loc_dly (cfg_loc_dly), .cfg_loc_long (cfg_loc_long),
   .cfg_exp_dly (cfg_exp_dly), .cfg_shift8 (cfg_shift8), .cfg_first (cfg_first),
   .local_sum (local_sum), .exp_in (exp_in), .loc_tap (loc_tap), .exp_tap (exp_tap),
   .sum_w (sum_w), .exp_out (exp_out)
);

// File: tb/test_cascade_sum_align.sv
module test_cascade_sum_align;
   typedef struct {
      logic [31:0] val;
      string       tag;
   } exp_item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  cfg_loc_dly = 2'b00;
   logic        cfg_loc_long = 1'b0;
   logic        cfg_exp_dly = 1'b0;
   logic        cfg_shift8 = 1'b0;
   logic        cfg_first = 1'b0;
   logic [21:0] local_sum = '0;
   logic [31:0] exp_in = '0;
   logic [31:0] exp_out;

   int errors = 0;
   int checks = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;
   exp_item_t   sb_q[$];
   logic [21:0] loc_h[$];
   logic [31:0] exp_h[$];

   always #5 clk = ~clk;

   cascade_sum_align i_cascade_sum_align (
      .clk (clk), .rst (rst), .cfg_loc_dly (cfg_loc_dly), .cfg_loc_long (cfg_loc_long),
      .cfg_exp_dly (cfg_exp_dly), .cfg_shift8 (cfg_shift8), .cfg_first (cfg_first),
      .local_sum (local_sum), .exp_in (exp_in), .exp_out (exp_out)
   );

   function automatic logic [31:0] model(int n);
      int dl = int'(cfg_loc_dly) * 4 + (cfg_loc_long ? 16 : 0);
      int de = cfg_exp_dly ? 4 : 0;
      int li = n - 4 - dl;
      int ei = n - 4 - de;
      logic [31:0] l = '0;
      logic [31:0] e = '0;
      if (li >= 0) l = {{10{loc_h[li][21]}}, loc_h[li]};
      if (cfg_shift8) l = l << 8;
      if (!cfg_first && ei >= 0) e = exp_h[ei];
      return l + e;
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] expv, input string tag);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: exp_out=%h expected=%h", tag, act, expv);
      end
   endtask

   // Driver: one call per clock; queues the expected value of the output now visible
   task automatic step(input logic [21:0] l, input logic [31:0] e, input string tag);
      exp_item_t it;
      @(negedge clk);
      if (chk_on) begin
         it.val = model(loc_h.size());
         it.tag = tag;
         sb_q.push_back(it);
      end
      local_sum = l;
      exp_in    = e;
      loc_h.push_back(l);
      exp_h.push_back(e);
   endtask

   // Monitor: compares the output with the queued expectation
   always @(negedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_item_t it;
         it = sb_q.pop_front();
         check(exp_out, it.val, it.tag);
      end
   end

   task automatic set_cfg(input logic [1:0] c, input logic lg, input logic ed,
                          input logic sh, input logic fi);
      chk_on = 1'b0;
      cfg_loc_dly = c; cfg_loc_long = lg; cfg_exp_dly = ed;
      cfg_shift8 = sh; cfg_first = fi;
      for (int i = 0; i < 40; i++) step('0, '0, "flush");
      loc_h.delete();
      exp_h.delete();
      chk_on = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #1500000;
      errors++;
      $display("FAIL watchdog: expired, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(exp_out, 32'h0, "R1 reset state");
      @(negedge clk);
      rst = 1'b0;

      // R2 / R3: impulse through every local delay setting
      for (int lg = 0; lg < 2; lg++) begin
         for (int c = 0; c < 4; c++) begin
            set_cfg(2'(c), 1'(lg), 1'b0, 1'b0, 1'b0);
            step(22'h000123, '0, lg ? "R3 local impulse" : "R2 local impulse");
            for (int i = 0; i < 36; i++)
               step('0, '0, lg ? "R3 local impulse" : "R2 local impulse");
         end
      end

      // R4: cascade impulse with and without extra delay
      for (int ed = 0; ed < 2; ed++) begin
         set_cfg(2'b01, 1'b0, 1'(ed), 1'b0, 1'b0);
         step('0, 32'h0000_0ABC, "R4 cascade impulse");
         for (int i = 0; i < 12; i++) step('0, '0, "R4 cascade impulse");
      end

      // R7: random streams on both inputs, mixed delays
      set_cfg(2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 60; i++) step(22'($urandom), $urandom, "R7 random sum");
      set_cfg(2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 60; i++) step(22'($urandom), $urandom, "R7 random sum long");

      // R5: head of chain ignores a busy cascade input
      set_cfg(2'b00, 1'b0, 1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 40; i++) step(22'($urandom), $urandom | 32'h1, "R5 first ignores cascade");

      // R6 / R8: shift with negative and positive local values
      set_cfg(2'b01, 1'b0, 1'b0, 1'b1, 1'b0);
      step(22'h3FFFFF, 32'h0000_0005, "R6 R8 shift of -1");
      step(22'h200000, '0, "R6 R8 shift of most negative");
      for (int i = 0; i < 40; i++) step(22'($urandom), $urandom, "R6 shifted random");

      // R8: negative local without shift
      set_cfg(2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
      step(22'h3FFFF0, 32'h0000_0100, "R8 sign extension");
      for (int i = 0; i < 10; i++) step(22'h200001, '0, "R8 sign extension");

      // R1: reset in the middle of traffic clears the pipelines
      for (int i = 0; i < 10; i++) step(22'($urandom), $urandom, "R7 pre-reset");
      while (sb_q.size() > 0) @(negedge clk);
      chk_on = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(exp_out, 32'h0, "R1 mid-stream reset");
      local_sum = '0;
      exp_in = '0;
      @(negedge clk);
      rst = 1'b0;
      loc_h.delete();
      exp_h.delete();
      chk_on = 1'b1;
      for (int i = 0; i < 8; i++) step(22'($urandom), $urandom, "R1 output after reset");

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule